// File: doc/BRIEF.md
# Receive Word Assembler

This block sits behind the capture stage of a 16-bit packet receive link. Each cycle it may take one 16-bit word and a flag that tells data from control. It packs data words, first word in the lowest lane, into a wide word of 32 or 64 bits. The width is fixed by a parameter, so the user side can run at one half or one quarter of the link word rate. A control word is never placed in the data field. It is decoded, and its meaning is carried out of band on the wide word it concerns. An end-of-packet status, a byte count and an error flag go on the last wide word of the packet before it. A start flag and a channel address go on the first wide word of the packet after it.

A small state machine tracks how full the wide word is. In `ST_EMPTY` no data is held. In `ST_FILL` some lanes hold data. In `ST_FULL` every lane holds data, and the word waits for the next input, because that input decides whether the word ends a packet. The transitions are:
- EMPTY→FILL on a data word.
- FILL→FILL on a data word that leaves a lane free.
- FILL→FULL on a data word that fills the last lane.
- FULL→FILL on a data word: the held word is emitted and a new word starts.
- FILL→EMPTY and FULL→EMPTY on a packet control word: the held word is flushed.

A packet control word seen in EMPTY only updates the pending start flag and address. Idle and training control words cause no transition.

A 4-bit rotating parity runs over the data words since the last packet control word. A wrong check field raises a parity-error flag on the next wide word that ends a packet.

Top module: `rxw_assembler`

## Requirements
- R1: After reset, `out_valid` is low, and it stays low until data has been received and emitted.
- R2: Data words fill lanes in arrival order. Lane i occupies bits [16i+15:16i], and the first word goes in lane 0. A completely filled word is emitted when the next data word arrives, with every lane valid, `out_bytes` = 2×lanes, and `out_eop` low.
- R3: A word with `in_ctl` high and bit 15 low is an idle or training word. It is ignored: it gives no output and does not change the packing, the start flag, the address or the parity.
- R4: A packet control word (`in_ctl` high, bit 15 high) that arrives while lanes are held flushes the wide word. `out_lane_vld` has ones for the filled lanes, starting at lane 0. Unfilled lanes are driven to zero.
- R5: Bit 12 of a packet control word marks a start, and bits 11:4 give the channel address. The first wide word loaded after that control word carries `out_sop`=1. Every wide word carries the address of the most recent packet control word that was seen before its first lane was loaded.
- R6: Bits 14:13 of a packet control word give the end status: 00 none, 01 error end, 10 end with both bytes of the last lane valid, 11 end with one byte valid. For a non-zero status the flushed word has `out_eop`=1 and `out_bytes` = 2×filled lanes, minus one when the status is 11.
- R7: End status 01 sets `out_err` together with `out_eop`, and `out_bytes` = 2×filled lanes.
- R8: Parity definition:
  - The accumulator starts at 4'hF and returns to 4'hF after each packet control word.
  - Each data word w updates it as acc = rotl1(acc) ^ w[15:12] ^ w[11:8] ^ w[7:4] ^ w[3:0].
  - A packet control word c expects c[3:0] = rotl1(acc) ^ c[15:12] ^ c[11:8] ^ c[7:4].
  - On a mismatch, `out_par_err` is set on the next emitted word that has `out_eop` high: either the word this control word flushes, or a later one.
- R9: A wide word appears on the outputs in the cycle after the input word that completes or flushes it.
- R10: A packet control word that arrives while no lanes are held emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An input word is present this cycle |
| in_ctl | input | 1 | 1 = control word, 0 = data word |
| in_word | input | 16 | Received word |
| out_valid | output | 1 | A wide word is presented this cycle |
| out_data | output | OUT_W | Packed data, lane 0 in the low bits |
| out_lane_vld | output | OUT_W/16 | Per-lane valid mask |
| out_bytes | output | clog2(OUT_W/8+1) | Valid byte count of this word |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |
| out_err | output | 1 | Packet ended with an error status |
| out_par_err | output | 1 | Parity mismatch reported on this end |
| out_addr | output | 8 | Channel address of the packet |

## Verification
A wrong fill count or state shows on the next emitted word, one cycle after the word that completes or flushes it. It appears as a shifted or duplicated lane, a mask that is not contiguous, or a wrong byte count. A lost pending start or address appears on the first word of the next packet. A bad parity accumulator can stay hidden until the next end of packet, where `out_par_err` then disagrees with the model. The bench sweeps every packet length from one to nine words against all three end statuses. It mixes in idle words, gaps and corrupted check fields, so every fill level meets every end code.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FILL  = 2'd1,
        ST_FULL  = 2'd2
    } pack_state_e;

    typedef enum logic [1:0] {
        END_NONE = 2'b00,
        END_ERR  = 2'b01,
        END_TWO  = 2'b10,
        END_ONE  = 2'b11
    } end_code_e;

    typedef struct packed {
        end_code_e   end_code;
        logic        sop;
        logic [7:0]  addr;
    } ctl_fields_t;

    localparam logic [3:0] PAR_SEED = 4'hF;

    function automatic logic [3:0] par_fold(input logic [15:0] w);
        return w[15:12] ^ w[11:8] ^ w[7:4] ^ w[3:0];
    endfunction

    function automatic logic [3:0] par_step(input logic [3:0] acc, input logic [15:0] w);
        return {acc[2:0], acc[3]} ^ par_fold(w);
    endfunction

endpackage

// File: rtl/rxw_ctl_decode.sv
module rxw_ctl_decode
    import rxw_pkg::*;
(
    input  logic        in_valid,
    input  logic        in_ctl,
    input  logic [15:4] hdr,
    output logic        data_stb,
    output logic        pkt_stb,
    output logic        idle_stb,
    output ctl_fields_t fields
);

    always_comb begin
        data_stb        = in_valid && !in_ctl;
        pkt_stb         = in_valid && in_ctl && hdr[15];
        idle_stb        = in_valid && in_ctl && !hdr[15];
        fields.end_code = end_code_e'(hdr[14:13]);
        fields.sop      = hdr[12];
        fields.addr     = hdr[11:4];
    end

endmodule

// File: rtl/rxw_parity.sv
module rxw_parity
    import rxw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        data_stb,
    input  logic        pkt_stb,
    input  logic [15:0] word,
    output logic        mismatch
);

    logic [3:0] acc_q;
    logic [3:0] expect_chk;

    always_comb begin
        expect_chk = par_step(acc_q, {word[15:4], 4'b0000});
        mismatch   = pkt_stb && (expect_chk != word[3:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= PAR_SEED;
        end else if (pkt_stb) begin
            acc_q <= PAR_SEED;
        end else if (data_stb) begin
            acc_q <= par_step(acc_q, word);
        end
    end

endmodule

// File: rtl/rxw_packer.sv
module rxw_packer
    import rxw_pkg::*;
#(
    parameter int LANES = 4,
    localparam int CW = $clog2(LANES + 1),
    localparam int LW = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int BW = $clog2(2 * LANES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  data_stb,
    input  logic                  pkt_stb,
    input  logic [15:0]           word,
    input  ctl_fields_t           fields,
    input  logic                  par_mismatch,
    output logic                  out_valid,
    output logic [16*LANES-1:0]   out_data,
    output logic [LANES-1:0]      out_lane_vld,
    output logic [BW-1:0]         out_bytes,
    output logic                  out_sop,
    output logic                  out_eop,
    output logic                  out_err,
    output logic                  out_par_err,
    output logic [7:0]            out_addr
);

    pack_state_e              state_q, state_d;
    logic [LANES-1:0][15:0]   buf_q;
    logic [CW-1:0]            cnt_q;
    logic [LW-1:0]            wr_lane;
    logic                     word_sop_q, pend_sop_q, sticky_q;
    logic [7:0]               word_addr_q, cur_addr_q;
    logic [LANES-1:0]         lane_mask;
    logic [BW-1:0]            flush_bytes;
    logic                     emit_full, emit_flush, load_first, ends_pkt_out;

    assign wr_lane      = cnt_q[LW-1:0];
    assign emit_full    = (state_q == ST_FULL) && data_stb;
    assign emit_flush   = (state_q != ST_EMPTY) && pkt_stb;
    assign load_first   = data_stb && (state_q != ST_FILL);
    assign ends_pkt_out = emit_flush && (fields.end_code != END_NONE);
    assign flush_bytes  = BW'(2 * int'(cnt_q))
                        - ((fields.end_code == END_ONE) ? BW'(1) : BW'(0));

    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign lane_mask[g] = (CW'(g) < cnt_q);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (data_stb) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (data_stb && (cnt_q == CW'(LANES - 1))) state_d = ST_FULL;
                else if (pkt_stb)                           state_d = ST_EMPTY;
            end
            ST_FULL: begin
                if (data_stb)     state_d = ST_FILL;
                else if (pkt_stb) state_d = ST_EMPTY;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // lane storage and packet context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q       <= '0;
            cnt_q       <= '0;
            word_sop_q  <= 1'b0;
            word_addr_q <= '0;
            pend_sop_q  <= 1'b0;
            cur_addr_q  <= '0;
            sticky_q    <= 1'b0;
        end else if (load_first) begin
            buf_q       <= '0;
            buf_q[0]    <= word;
            cnt_q       <= CW'(1);
            word_sop_q  <= pend_sop_q;
            word_addr_q <= cur_addr_q;
            pend_sop_q  <= 1'b0;
        end else if (data_stb) begin
            buf_q[wr_lane] <= word;
            cnt_q          <= cnt_q + CW'(1);
        end else if (pkt_stb) begin
            pend_sop_q <= fields.sop;
            cur_addr_q <= fields.addr;
            sticky_q   <= ends_pkt_out ? 1'b0 : (sticky_q | par_mismatch);
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_data     <= '0;
            out_lane_vld <= '0;
            out_bytes    <= '0;
            out_sop      <= 1'b0;
            out_eop      <= 1'b0;
            out_err      <= 1'b0;
            out_par_err  <= 1'b0;
            out_addr     <= '0;
        end else begin
            out_valid <= emit_full || emit_flush;
            if (emit_full || emit_flush) begin
                out_data <= buf_q;
                out_sop  <= word_sop_q;
                out_addr <= word_addr_q;
                if (emit_full) begin
                    out_lane_vld <= '1;
                    out_bytes    <= BW'(2 * LANES);
                    out_eop      <= 1'b0;
                    out_err      <= 1'b0;
                    out_par_err  <= 1'b0;
                end else begin
                    out_lane_vld <= lane_mask;
                    out_bytes    <= flush_bytes;
                    out_eop      <= ends_pkt_out;
                    out_err      <= (fields.end_code == END_ERR);
                    out_par_err  <= ends_pkt_out && (sticky_q || par_mismatch);
                end
            end
        end
    end

    AST_FULL_DATA_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL && data_stb) |=> (out_valid && out_lane_vld == '1 && !out_eop)); // R2
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LANES)); // R2
    AST_EMPTY_CTL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY && pkt_stb) |=> !out_valid); // R10
    AST_LANES_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_lane_vld[0] && ((out_lane_vld & (out_lane_vld + LANES'(1))) == '0))); // R4
    AST_ERR_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_eop && out_bytes == BW'(2 * $countones(out_lane_vld)))); // R7
    AST_PERR_ON_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        out_par_err |-> out_eop); // R8

endmodule

// File: rtl/rxw_assembler.sv
module rxw_assembler
    import rxw_pkg::*;
#(
    parameter int OUT_W = 64,
    localparam int LANES = OUT_W / 16,
    localparam int BW = $clog2(2 * LANES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_ctl,
    input  logic [15:0]       in_word,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data,
    output logic [LANES-1:0]  out_lane_vld,
    output logic [BW-1:0]     out_bytes,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_err,
    output logic              out_par_err,
    output logic [7:0]        out_addr
);

    logic        data_stb, pkt_stb, idle_stb, par_mismatch;
    ctl_fields_t fields;

    rxw_ctl_decode u_decode (
        .in_valid (in_valid),
        .in_ctl   (in_ctl),
        .hdr      (in_word[15:4]),
        .data_stb (data_stb),
        .pkt_stb  (pkt_stb),
        .idle_stb (idle_stb),
        .fields   (fields)
    );

    rxw_parity u_parity (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_stb (data_stb),
        .pkt_stb  (pkt_stb),
        .word     (in_word),
        .mismatch (par_mismatch)
    );

    rxw_packer #(.LANES(LANES)) u_packer (
        .clk          (clk),
        .rst_n        (rst_n),
        .data_stb     (data_stb),
        .pkt_stb      (pkt_stb),
        .word         (in_word),
        .fields       (fields),
        .par_mismatch (par_mismatch),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_lane_vld (out_lane_vld),
        .out_bytes    (out_bytes),
        .out_sop      (out_sop),
        .out_eop      (out_eop),
        .out_err      (out_err),
        .out_par_err  (out_par_err),
        .out_addr     (out_addr)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle_stb |=> !out_valid); // R3

endmodule

// File: tb/rxw_assembler_test.sv
module rxw_assembler_test;

    localparam int OUT_W = 64;
    localparam int LANES = OUT_W / 16;
    localparam int BW    = $clog2(2 * LANES + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ctl = 1'b0;
    logic [15:0]       in_word = '0;
    logic              out_valid, out_sop, out_eop, out_err, out_par_err;
    logic [OUT_W-1:0]  out_data;
    logic [LANES-1:0]  out_lane_vld;
    logic [BW-1:0]     out_bytes;
    logic [7:0]        out_addr;

    always #5 clk = ~clk;

    rxw_assembler #(.OUT_W(OUT_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctl(in_ctl), .in_word(in_word),
        .out_valid(out_valid), .out_data(out_data), .out_lane_vld(out_lane_vld),
        .out_bytes(out_bytes), .out_sop(out_sop), .out_eop(out_eop), .out_err(out_err),
        .out_par_err(out_par_err), .out_addr(out_addr)
    );

    int n_run = 0;
    int n_fail = 0;
    int gcnt = 0;

    logic [OUT_W-1:0] cap_data  [0:15];
    logic [LANES-1:0] cap_lv    [0:15];
    logic [BW-1:0]    cap_bytes [0:15];
    logic [3:0]       cap_flags [0:15];
    logic [7:0]       cap_addr  [0:15];

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (gcnt < 16) begin
                cap_data[gcnt]  = out_data;
                cap_lv[gcnt]    = out_lane_vld;
                cap_bytes[gcnt] = out_bytes;
                cap_flags[gcnt] = {out_sop, out_eop, out_err, out_par_err};
                cap_addr[gcnt]  = out_addr;
            end
            gcnt = gcnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    logic [3:0] m_acc = 4'hF;
    bit         m_sticky = 1'b0;

    function automatic logic [3:0] m_step(input logic [3:0] a, input logic [15:0] w);
        return {a[2:0], a[3]} ^ w[15:12] ^ w[11:8] ^ w[7:4] ^ w[3:0];
    endfunction

    task automatic put(input bit c, input logic [15:0] w);
        @(negedge clk); #1;
        in_valid = 1'b1; in_ctl = c; in_word = w;
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            in_valid = 1'b0; in_ctl = 1'b0; in_word = '0;
        end
    endtask

    task automatic send_ctl(input logic [1:0] code, input bit sop, input logic [7:0] addr, input bit bad);
        logic [15:0] w;
        w = {1'b1, code, sop, addr, 4'h0};
        w[3:0] = m_step(m_acc, w) ^ {3'b000, bad};
        m_acc = 4'hF;
        put(1'b1, w);
    endtask

    task automatic run_pkt(input int n, input int code, input logic [7:0] addr,
                           input bit mid_idle, input bit mid_gap, input bit bad_sop, input bit bad_end);
        logic [15:0] vals [0:15];
        logic [63:0] ed;
        bit e_perr;
        int nw, c;
        @(negedge clk); #1;
        gcnt = 0;
        send_ctl(2'b00, 1'b1, addr, bad_sop);
        if (bad_sop) m_sticky = 1'b1;
        for (int i = 0; i < n; i++) begin
            vals[i] = 16'(int'(addr) * 257 + i * 4099 + n * 13);
            put(1'b0, vals[i]);
            m_acc = m_step(m_acc, vals[i]);
            if (mid_idle && i == 0) put(1'b1, 16'h7FF5);
            if (mid_gap && i == 1) gap(2);
        end
        e_perr = m_sticky || bad_end;
        m_sticky = 1'b0;
        send_ctl(2'(code), 1'b0, ~addr, bad_end);
        @(negedge clk);
        chk("R9 flush latency", {62'd0, out_valid, out_eop}, 64'd3);
        #1;
        in_valid = 1'b0; in_ctl = 1'b0; in_word = '0;
        gap(2);
        nw = (n + LANES - 1) / LANES;
        chk("R10 R2 word count", 64'(gcnt), 64'(nw));
        for (int k = 0; k < nw && k < gcnt; k++) begin
            c = (k == nw - 1) ? (n - LANES * k) : LANES;
            ed = '0;
            for (int l = 0; l < c; l++) ed[16*l +: 16] = vals[LANES*k + l];
            chk("R2 R4 lane data", cap_data[k], ed);
            if (mid_idle && k == 0) chk("R3 idle word skipped", cap_data[k], ed);
            chk("R4 lane mask", 64'(cap_lv[k]), 64'((1 << c) - 1));
            chk("R5 start flag", 64'(cap_flags[k][3]), 64'(k == 0));
            chk("R5 address", 64'(cap_addr[k]), 64'(addr));
            chk("R6 end flag", 64'(cap_flags[k][2]), 64'(k == nw - 1));
            chk("R7 error flag", 64'(cap_flags[k][1]), 64'((k == nw - 1) && code == 1));
            chk("R6 R7 byte count", 64'(cap_bytes[k]),
                64'(2 * c - (((k == nw - 1) && code == 3) ? 1 : 0)));
            chk("R8 parity flag", 64'(cap_flags[k][0]), 64'((k == nw - 1) && e_perr));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int p;
        p = 0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 reset output idle", 64'(out_valid), 64'd0);
        chk("R1 no words after reset", 64'(gcnt), 64'd0);
        for (int n = 1; n <= 9; n++) begin
            for (int code = 1; code <= 3; code++) begin
                run_pkt(n, code, 8'(p * 37 + 5), (p % 2) == 1, (p % 3) == 0,
                        (p % 7) == 3, (p % 5) == 2);
                gap(1);
                p++;
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule